// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned N-bit operands over several clock cycles. It uses one N-bit adder, so its cost stays small. A start pulse loads the multiplicand and the multiplier and clears the accumulating product. The block then works through the multiplier one bit at a time, with three control steps for each bit.

In the first step, the multiplicand is added into the upper half of the product register when the current multiplier LSB is 1. The carry out of that add goes into a single extension flip-flop above the product's MSB. In the second step, the extension bit, the product and the multiplier all shift right by one place, and the extension bit is cleared. In the third step, an iteration counter advances.

When the counter reaches N, the product register holds the full 2N-bit result and the done flag rises. The flag stays high until a new start pulse is accepted.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0.
- R2: For unsigned operands a and b, the `product` shown while `done` is high equals a*b. For example, 12 and 11 give 132 (8'b10000100).
- R3: `done` rises exactly 3*N clock edges after the edge that accepts `start`, which is one add, one shift and one count step per multiplier bit. At that moment the iteration count equals N.
- R4: A `start` pulse that arrives while an operation is in progress is ignored. It does not change the result or the latency of that operation.
- R5: While `done` is high and `start` is low, `done` stays high and `product` does not change.
- R6: If either operand is 0, the product is 0 after the full N iterations.
- R7: A `start` pulse accepted while `done` is high clears `done` on the next edge and begins a new operation with the new operands.
- R8: The carry extension bit is cleared after each shift. As a result, the largest operands ((2^N-1)*(2^N-1)) give the exact product with no lost or extra high bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a multiplication |
| multiplicand | input | N | Unsigned multiplicand, sampled when start is accepted |
| multiplier | input | N | Unsigned multiplier, sampled when start is accepted |
| product | output | 2N | Product register; it holds the result while done is high |
| done | output | 1 | High from completion until the next accepted start |

## Verification
Two events can land on the same clock edge: a new start request and an operation still in progress, including its final count step. The bench provokes this by raising `start` with different operands at a chosen cycle inside a running multiplication, and on the very edge where the last count completes. It judges the outcome by checking that the original product and the 3*N latency are unchanged. A second collision is a start pulse in the cycle where `done` is high. Here the bench checks that `done` falls on the next edge and that the following result matches the new operands.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADD   = 3'd1,
    ST_SHIFT = 3'd2,
    ST_COUNT = 3'd3,
    ST_DONE  = 3'd4
  } sam_state_t;

  // Upper half plus multiplicand, returned with its carry as the top bit.
  function automatic logic [16:0] upper_sum(input logic [15:0] hi, input logic [15:0] m, input int unsigned w);
    logic [16:0] s;
    logic [16:0] mask;
    mask = (17'd1 << w) - 17'd1;
    s = ({1'b0, hi} & mask) + ({1'b0, m} & mask);
    return s;
  endfunction
endpackage

// File: rtl/sam_ctrl.sv
module sam_ctrl import sam_pkg::*; #(
  parameter int N = 4,
  localparam int SCW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           load_en,
  output logic           add_en,
  output logic           shift_en,
  output logic           busy,
  output logic           done,
  output logic [SCW-1:0] sc
);
  sam_state_t st_q, st_d;
  logic       last_step;

  assign last_step = (sc == SCW'(N - 1));
  assign busy      = (st_q == ST_ADD) || (st_q == ST_SHIFT) || (st_q == ST_COUNT);
  assign done      = (st_q == ST_DONE);
  assign load_en   = start && !busy;
  assign add_en    = (st_q == ST_ADD);
  assign shift_en  = (st_q == ST_SHIFT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (start) st_d = ST_ADD;
      ST_ADD:           st_d = ST_SHIFT;
      ST_SHIFT:         st_d = ST_COUNT;
      ST_COUNT:         st_d = last_step ? ST_DONE : ST_ADD;
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      sc   <= '0;
    end else begin
      st_q <= st_d;
      if (load_en)                sc <= '0;
      else if (st_q == ST_COUNT)  sc <= sc + SCW'(1);
    end
  end
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath import sam_pkg::*; #(
  parameter int N = 4,
  localparam int PW = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          add_en,
  input  logic          shift_en,
  input  logic [N-1:0]  a_in,
  input  logic [N-1:0]  b_in,
  output logic [PW-1:0] p,
  output logic [N-1:0]  m_val,
  output logic          carry
);
  logic [N-1:0] q_val;
  logic [16:0]  sum_w;

  assign sum_w = upper_sum(16'(p[PW-1:N]), 16'(m_val), N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p     <= '0;
      m_val <= '0;
      q_val <= '0;
      carry <= 1'b0;
    end else if (load_en) begin
      p     <= '0;
      m_val <= a_in;
      q_val <= b_in;
      carry <= 1'b0;
    end else if (add_en) begin
      if (q_val[0]) begin
        p[PW-1:N] <= sum_w[N-1:0];
        carry     <= sum_w[N];
      end
    end else if (shift_en) begin
      p     <= {carry, p[PW-1:1]};
      carry <= 1'b0;
      q_val <= q_val >> 1;
    end
  end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul import sam_pkg::*; #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic [2*N-1:0] product,
  output logic           done
);
  localparam int SCW = $clog2(N + 1);

  logic           load_en, add_en, shift_en, busy;
  logic           carry_w;
  logic [SCW-1:0] sc_w;
  logic [N-1:0]   m_w;

  sam_ctrl #(.N(N)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load_en(load_en), .add_en(add_en), .shift_en(shift_en),
    .busy(busy), .done(done), .sc(sc_w)
  );

  sam_datapath #(.N(N)) dp_i (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_en), .add_en(add_en), .shift_en(shift_en),
    .a_in(multiplicand), .b_in(multiplier),
    .p(product), .m_val(m_w), .carry(carry_w)
  );
endmodule

// File: rtl/sam_chk.sv
module sam_chk #(
  parameter int N = 4,
  localparam int SCW = $clog2(N + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           done,
  input logic [2*N-1:0] product,
  input logic           busy,
  input logic           shift_en,
  input logic           carry,
  input logic [SCW-1:0] sc,
  input logic [N-1:0]   m_val
);
  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(product));

  p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done);

  p_busy_ignores_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(m_val));

  p_done_at_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> sc == SCW'(N));

  p_carry_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !carry);

  always @(posedge clk) begin
    if (rst_n) begin
      p_count_bound_r3: assert (sc <= SCW'(N));
    end
  end
endmodule

bind shift_add_mul sam_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .product(product),
  .busy(busy), .shift_en(shift_en), .carry(carry_w), .sc(sc_w), .m_val(m_w)
);

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb_top;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3 * N;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplier = '0;
  logic [2*N-1:0] product;
  logic           done;

  int n_chk = 0;
  int n_bad = 0;

  shift_add_mul #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .multiplicand(mcand), .multiplier(mplier),
    .product(product), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [2*N-1:0] acc = '0;
    for (int i = 0; i < N; i++)
      if (b[i]) acc = acc + ({{N{1'b0}}, a} << i);
    return acc;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one multiplication. intr_at >= 0 raises a stray start at that cycle.
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input int intr_at, input string req);
    int cyc;
    bit was_done;
    was_done = done;
    mcand = a; mplier = b; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    if (was_done) check("R7 done clears", done, 0);
    cyc = 0;
    while (!done && cyc < 4 * LAT) begin
      if (cyc == intr_at) begin
        mcand = ~a; mplier = ~b; start = 1'b1;
      end
      @(posedge clk); cyc++; @(negedge clk);
      start = 1'b0;
    end
    check({req, " latency R3"}, cyc, LAT);
    check({req, " product R2"}, product, ref_mul(a, b));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 product", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle done", done, 0);

    run_op(4'd12, 4'd11, -1, "R2 12x11");
    check("R2 132", product, 8'b10000100);
    run_op(4'd15, 4'd15, -1, "R8 max");
    check("R8 max value", product, 8'd225);
    run_op(4'd0, 4'd13, -1, "R6 a0");
    check("R6 zero a", product, 0);
    run_op(4'd9, 4'd0, -1, "R6 b0");
    check("R6 zero b", product, 0);

    // R5: done held and product stable with no start
    repeat (5) @(negedge clk);
    check("R5 done held", done, 1);
    check("R5 product held", product, ref_mul(4'd9, 4'd0));

    // R4: stray starts mid-operation and on the final count edge
    run_op(4'd7, 4'd6, 2, "R4 mid");
    run_op(4'd13, 4'd5, LAT - 1, "R4 last");
    run_op(4'd3, 4'd10, 0, "R4 first");

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_op(N'(a), N'(b), -1, "R2 exh");

    for (int k = 0; k < 40; k++)
      run_op(N'($urandom), N'($urandom), int'($urandom % LAT), "R4 rnd");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule